// File: doc/BRIEF.md
# Video-Mode Display Line Packet Sequencer

This block turns a set of frame timing values and a stream of 24-bit pixels into the serial byte stream for one display link running in non-burst video mode with sync events. It runs on the byte clock, which is the per-lane bit rate divided by eight. It produces frames back to back after reset. Every line has the same four packets in a fixed order:

- a 4-byte sync short packet;
- a back-porch blanking long packet;
- a middle long packet that carries pixels on active lines and blanking elsewhere;
- a front-porch blanking long packet.

Each long packet consists of a 4-byte header with ECC, a payload whose length in bytes is set by a register, and a 2-byte CRC.

The vertical order is the sync lines, then the back-porch lines, then the active lines, then the front-porch lines. The block reads the timing inputs only at the moment a frame begins, so software can change them at any time. Pixels arrive on a valid/ready input. If a pixel is needed and none is offered, the block holds its output and flags an underflow. Downstream logic takes the byte stream, using the packet-start marker, and spreads it over the lanes.

The control is a five-state machine. IDLE lasts one cycle after reset and loads the timing. SHORT sends the sync packet's 4 bytes. HDR sends a long header. PAY sends the payload. CRC sends the checksum. The transitions are:

- IDLE→SHORT, always.
- SHORT→HDR, after byte 3.
- HDR→PAY, after byte 3 when the word count is non-zero.
- HDR→CRC, after byte 3 when the word count is zero.
- PAY→CRC, after the last payload byte.
- CRC→HDR, after the back-porch and middle packets.
- CRC→SHORT, after the front-porch packet. This is the line end. On the last line it is also the frame end, and it reloads the timing.

Top module: `dsi_vid_seq`

## Requirements
- R1: Each line is one short packet followed by three long packets: back porch, middle, front porch. `out_sop` is high only on the first byte of each packet, and only while `out_valid` is high.
- R2: The short packet bytes are DI, 0x00, 0x00, ECC. DI holds the virtual channel in bits [7:6] and the data type in bits [5:0]. The data type is 0x01 on line 0 of a frame whose sync count is at least 1, and 0x21 on every other line.
- R3: A long packet header is DI, then the word count's low byte, then its high byte, then ECC. The payload is word-count bytes long: back porch uses the back-porch count, the middle packet uses the active count, and front porch uses the front-porch count. A zero word count goes straight from ECC to CRC.
- R4: Bits [5:0] of the ECC byte are the XOR of per-bit codes over the 24 header bits {WC high, WC low, DI} with DI in bits [7:0]. Bits [7:6] are zero. The codes for bits 0 to 23 are 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B (hex).
- R5: The two bytes after the payload are a CRC-16 with polynomial x^16+x^12+x^5+1. It is bit-reflected (0x8408), uses seed 0xFFFF and no final XOR, and is computed LSB first over the payload. The low byte is sent first. An empty payload gives 0xFFFF.
- R6: A frame has sync lines, then back-porch lines, then active lines, then front-porch lines. The middle packet has data type 0x3E carrying pixels on active lines and 0x19 carrying zeros elsewhere. Both porch packets are 0x19 with zero bytes.
- R7: Active payload bytes take each pixel in the order bits [7:0], [15:8], [23:16]. One pixel is accepted each time a payload byte at a multiple of 3 is due, and `pix_ready` is high only then. Bytes left unused when the count is not a multiple of 3 are dropped.
- R8: When a pixel is due and `pix_valid` is low, `out_valid` is low, `underflow` is high and the sequence holds its position. In every other cycle `underflow` is low.
- R9: Frames follow each other with no gap. The timing and channel inputs are sampled only in the cycle a frame begins, so a change during a frame first shows in the next frame.
- R10: While reset is active, `out_valid`, `out_sop`, `pix_ready` and `underflow` are low. The first byte of the first frame is valid in the cycle after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_vc | input | 2 | Virtual channel for all packets |
| cfg_hact_wc | input | WC_W | Middle packet payload length in bytes |
| cfg_hbp_wc | input | WC_W | Back-porch payload length in bytes |
| cfg_hfp_wc | input | WC_W | Front-porch payload length in bytes |
| cfg_vsa | input | LINE_W | Number of sync lines |
| cfg_vbp | input | LINE_W | Number of vertical back-porch lines |
| cfg_vact | input | LINE_W | Number of active lines |
| cfg_vfp | input | LINE_W | Number of vertical front-porch lines |
| pix_data | input | PIX_W | Pixel, with the first byte sent in [7:0] |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | A pixel is taken this cycle if valid |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | `out_data` holds a byte this cycle |
| out_sop | output | 1 | First byte of a packet |
| underflow | output | 1 | Output held waiting for a pixel |

## Verification
Two events can fall in the same cycle. The last front-porch CRC byte of the final line is both a line step and a frame reload, and the reload must win so that the next frame starts at line 0 with a sync-start packet built from the new values. The bench changes the timing inputs a few bytes into every frame, and it sweeps sync, porch and active counts that include zero. It then checks each following frame byte by byte against a stream it computes from the new values. Pixel starvation can also coincide with the first payload byte right after a header, and can recur at every pixel boundary. Gap patterns of several periods are used to provoke this. In each stall cycle the bench checks the flag and the held output, and it checks that the accepted pixel order continues unbroken.

// File: rtl/dsi_vid_pkg.sv
`timescale 1ns/1ps
package dsi_vid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHORT,
        ST_HDR,
        ST_PAY,
        ST_CRC
    } seq_st_t;

    typedef enum logic [1:0] {
        PK_BP,
        PK_MID,
        PK_FP
    } pkt_t;

    typedef enum logic [1:0] {
        RG_SYNC,
        RG_VBP,
        RG_ACT,
        RG_VFP
    } vreg_t;

    localparam logic [5:0] DT_VSS   = 6'h01;
    localparam logic [5:0] DT_HSS   = 6'h21;
    localparam logic [5:0] DT_BLANK = 6'h19;
    localparam logic [5:0] DT_RGB24 = 6'h3E;

    // Parity row masks over {WC hi, WC lo, DI}
    localparam logic [23:0] ECC_ROW [0:5] = '{
        24'hF12CB7, 24'hF2555B, 24'h749A6D,
        24'hB8E38E, 24'hDF03F0, 24'hEFFC00
    };

    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam logic [15:0] CRC_SEED     = 16'hFFFF;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/dsi_hdr_ecc.sv
`timescale 1ns/1ps
module dsi_hdr_ecc
    import dsi_vid_pkg::*;
(
    input  logic [23:0] hdr,
    output logic [7:0]  ecc
);
    for (genvar i = 0; i < 6; i++) begin : g_par
        assign ecc[i] = ^(hdr & ECC_ROW[i]);
    end
    assign ecc[7:6] = 2'b00;
endmodule

// File: rtl/dsi_crc16.sv
`timescale 1ns/1ps
module dsi_crc16
    import dsi_vid_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= CRC_SEED;
        end else if (clr) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc16_step(crc, din);
        end
    end
endmodule

// File: rtl/dsi_vline_ctr.sv
`timescale 1ns/1ps
module dsi_vline_ctr
    import dsi_vid_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LINE_W-1:0] cfg_vsa,
    input  logic [LINE_W-1:0] cfg_vbp,
    input  logic [LINE_W-1:0] cfg_vact,
    input  logic [LINE_W-1:0] cfg_vfp,
    output vreg_t             region,
    output logic              vss_line,
    output logic              frame_last
);
    localparam int SUM_W = LINE_W + 2;

    logic [LINE_W-1:0] vsa_q, vbp_q, vact_q, vfp_q;
    logic [SUM_W-1:0]  ln_q;
    logic [SUM_W-1:0]  b_sync, b_vbp, b_act, b_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsa_q  <= '0;
            vbp_q  <= '0;
            vact_q <= '0;
            vfp_q  <= '0;
            ln_q   <= '0;
        end else if (load) begin
            vsa_q  <= cfg_vsa;
            vbp_q  <= cfg_vbp;
            vact_q <= cfg_vact;
            vfp_q  <= cfg_vfp;
            ln_q   <= '0;
        end else if (step) begin
            ln_q <= frame_last ? '0 : ln_q + SUM_W'(1);
        end
    end

    always_comb begin
        b_sync = SUM_W'(vsa_q);
        b_vbp  = b_sync + SUM_W'(vbp_q);
        b_act  = b_vbp + SUM_W'(vact_q);
        b_all  = b_act + SUM_W'(vfp_q);
        if (ln_q < b_sync)     region = RG_SYNC;
        else if (ln_q < b_vbp) region = RG_VBP;
        else if (ln_q < b_act) region = RG_ACT;
        else                   region = RG_VFP;
        vss_line   = (ln_q == '0) && (vsa_q != '0);
        frame_last = (ln_q + SUM_W'(1)) >= b_all;
    end
endmodule

// File: rtl/dsi_vid_seq.sv
`timescale 1ns/1ps
module dsi_vid_seq
    import dsi_vid_pkg::*;
#(
    parameter int WC_W   = 16,
    parameter int LINE_W = 12,
    parameter int PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_vc,
    input  logic [WC_W-1:0]   cfg_hact_wc,
    input  logic [WC_W-1:0]   cfg_hbp_wc,
    input  logic [WC_W-1:0]   cfg_hfp_wc,
    input  logic [LINE_W-1:0] cfg_vsa,
    input  logic [LINE_W-1:0] cfg_vbp,
    input  logic [LINE_W-1:0] cfg_vact,
    input  logic [LINE_W-1:0] cfg_vfp,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              underflow
);
    localparam int BPP    = PIX_W / 8;
    localparam int PH_W   = (BPP > 1) ? $clog2(BPP) : 1;
    localparam int HOLD_W = PIX_W - 8;

    seq_st_t           st_q, st_d;
    pkt_t              pkt_q;
    logic [WC_W-1:0]   cnt_q;
    logic [PH_W-1:0]   ph_q;
    logic [HOLD_W-1:0] hold_q;
    logic [1:0]        vc_q;
    logic [WC_W-1:0]   hact_q, hbp_q, hfp_q;

    vreg_t             region;
    logic              vss_line, frame_last;
    logic [WC_W-1:0]   wc_sel;
    logic              is_pix, need_pix, stall, adv;
    logic              short_end, hdr_end, pay_end, crc_end, line_end, frame_end;
    logic              load_cfg;
    logic [7:0]        di_short, di_long, ecc_byte;
    logic [23:0]       ecc_in;
    logic [15:0]       crc_val;

    // Packet selection and sequencing conditions
    always_comb begin
        unique case (pkt_q)
            PK_BP:   wc_sel = hbp_q;
            PK_MID:  wc_sel = hact_q;
            default: wc_sel = hfp_q;
        endcase
        is_pix    = (pkt_q == PK_MID) && (region == RG_ACT);
        need_pix  = (st_q == ST_PAY) && is_pix && (ph_q == '0);
        stall     = need_pix && !pix_valid;
        adv       = !stall;
        di_short  = {vc_q, vss_line ? DT_VSS : DT_HSS};
        di_long   = {vc_q, is_pix ? DT_RGB24 : DT_BLANK};
        ecc_in    = (st_q == ST_SHORT) ? {16'h0000, di_short}
                                       : {wc_sel[15:0], di_long};
        short_end = (st_q == ST_SHORT) && (cnt_q == WC_W'(3));
        hdr_end   = (st_q == ST_HDR)   && (cnt_q == WC_W'(3));
        pay_end   = (st_q == ST_PAY)   && (cnt_q == wc_sel - WC_W'(1));
        crc_end   = (st_q == ST_CRC)   && (cnt_q == WC_W'(1));
        line_end  = crc_end && (pkt_q == PK_FP);
        frame_end = line_end && frame_last;
        load_cfg  = (st_q == ST_IDLE) || (frame_end && adv);
    end

    // Next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  st_d = ST_SHORT;
            ST_SHORT: if (short_end) st_d = ST_HDR;
            ST_HDR:   if (hdr_end) st_d = (wc_sel == '0) ? ST_CRC : ST_PAY;
            ST_PAY:   if (pay_end) st_d = ST_CRC;
            ST_CRC:   if (crc_end) st_d = (pkt_q == PK_FP) ? ST_SHORT : ST_HDR;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pkt_q  <= PK_BP;
            cnt_q  <= '0;
            vc_q   <= '0;
            hact_q <= '0;
            hbp_q  <= '0;
            hfp_q  <= '0;
        end else begin
            if (load_cfg) begin
                vc_q   <= cfg_vc;
                hact_q <= cfg_hact_wc;
                hbp_q  <= cfg_hbp_wc;
                hfp_q  <= cfg_hfp_wc;
            end
            if (adv) begin
                st_q  <= st_d;
                cnt_q <= (st_d != st_q) ? '0 : cnt_q + WC_W'(1);
                if (crc_end) begin
                    unique case (pkt_q)
                        PK_BP:   pkt_q <= PK_MID;
                        PK_MID:  pkt_q <= PK_FP;
                        default: pkt_q <= PK_BP;
                    endcase
                end
            end
        end
    end

    // Pixel phase and held bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            hold_q <= '0;
        end else if (st_q != ST_PAY) begin
            ph_q <= '0;
        end else if (adv && is_pix) begin
            ph_q <= (ph_q == PH_W'(BPP - 1)) ? '0 : ph_q + PH_W'(1);
            if (ph_q == '0) hold_q <= pix_data[PIX_W-1:8];
            else            hold_q <= hold_q >> 8;
        end
    end

    // Output decode
    always_comb begin
        out_valid = (st_q != ST_IDLE) && adv;
        out_data  = 8'h00;
        out_sop   = 1'b0;
        pix_ready = need_pix;
        underflow = stall;
        unique case (st_q)
            ST_IDLE: out_data = 8'h00;
            ST_SHORT: begin
                out_sop = (cnt_q == '0);
                unique case (cnt_q[1:0])
                    2'd0:    out_data = di_short;
                    2'd3:    out_data = ecc_byte;
                    default: out_data = 8'h00;
                endcase
            end
            ST_HDR: begin
                out_sop = (cnt_q == '0);
                unique case (cnt_q[1:0])
                    2'd0:    out_data = di_long;
                    2'd1:    out_data = wc_sel[7:0];
                    2'd2:    out_data = wc_sel[15:8];
                    default: out_data = ecc_byte;
                endcase
            end
            ST_PAY: begin
                if (is_pix) out_data = (ph_q == '0) ? pix_data[7:0] : hold_q[7:0];
            end
            ST_CRC: out_data = cnt_q[0] ? crc_val[15:8] : crc_val[7:0];
            default: out_data = 8'h00;
        endcase
    end

    dsi_hdr_ecc u_ecc (
        .hdr (ecc_in),
        .ecc (ecc_byte)
    );

    dsi_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q == ST_HDR),
        .en    (out_valid && (st_q == ST_PAY)),
        .din   (out_data),
        .crc   (crc_val)
    );

    dsi_vline_ctr #(.LINE_W(LINE_W)) u_vline (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_cfg),
        .step       (line_end && adv),
        .cfg_vsa    (cfg_vsa),
        .cfg_vbp    (cfg_vbp),
        .cfg_vact   (cfg_vact),
        .cfg_vfp    (cfg_vfp),
        .region     (region),
        .vss_line   (vss_line),
        .frame_last (frame_last)
    );
endmodule

// File: rtl/dsi_vid_seq_chk.sv
`timescale 1ns/1ps
module dsi_vid_seq_chk
    import dsi_vid_pkg::*;
#(
    parameter int WC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            out_valid,
    input logic            out_sop,
    input logic            pix_valid,
    input logic            pix_ready,
    input logic            underflow,
    input seq_st_t         st,
    input logic [WC_W-1:0] cnt
);
    a_r1_sop_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    a_r2_short_then_header: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHORT && cnt == WC_W'(3) && out_valid) |=> out_sop);

    a_r5_crc_two_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CRC && cnt == '0 && out_valid) |=> (st == ST_CRC && out_valid && !out_sop));

    a_r7_gap_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> !pix_ready);

    a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (pix_ready && !out_sop));

    a_r8_flag_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ready |-> !underflow);
endmodule

bind dsi_vid_seq dsi_vid_seq_chk #(.WC_W(WC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .underflow (underflow),
    .st        (st_q),
    .cnt       (cnt_q)
);

// File: tb/sim_dsi_vid_seq.sv
`timescale 1ns/1ps
module sim_dsi_vid_seq;
    localparam int NCFG = 6;
    localparam int WD   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_vc;
    logic [15:0] cfg_hact_wc, cfg_hbp_wc, cfg_hfp_wc;
    logic [11:0] cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp;
    logic [23:0] pix_data;
    logic        pix_valid, pix_ready;
    logic [7:0]  out_data;
    logic        out_valid, out_sop, underflow;

    always #2 clk = ~clk;

    dsi_vid_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_vc(cfg_vc),
        .cfg_hact_wc(cfg_hact_wc), .cfg_hbp_wc(cfg_hbp_wc), .cfg_hfp_wc(cfg_hfp_wc),
        .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
        .underflow(underflow)
    );

    int c_vc   [NCFG] = '{0, 1, 2, 3, 0, 1};
    int c_hact [NCFG] = '{6, 9, 4, 3, 0, 12};
    int c_hbp  [NCFG] = '{3, 0, 1, 0, 2, 5};
    int c_hfp  [NCFG] = '{1, 2, 0, 0, 2, 4};
    int c_vsa  [NCFG] = '{1, 2, 0, 1, 1, 1};
    int c_vbp  [NCFG] = '{1, 0, 1, 1, 0, 2};
    int c_vact [NCFG] = '{2, 1, 2, 1, 0, 3};
    int c_vfp  [NCFG] = '{1, 0, 1, 1, 1, 2};
    int c_gap  [NCFG] = '{0, 2, 3, 4, 0, 5};

    logic [5:0] col_code [24] = '{
        6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
        6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
        6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
    };

    logic [7:0] exp_q [$];
    logic       sop_q [$];
    string      tag_q [$];
    int         checks = 0;
    int         errors = 0;
    int         pe     = 0;

    function automatic logic [23:0] pixval(input int n);
        return {8'(n * 37 + 11), 8'(n * 13 + 5), 8'(n * 7 + 1)};
    endfunction

    function automatic logic [7:0] calc_ecc(input logic [23:0] h);
        logic [5:0] s = '0;
        for (int i = 0; i < 24; i++) if (h[i]) s ^= col_code[i];
        return {2'b00, s};
    endfunction

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic fb;
        for (int j = 0; j < 8; j++) begin
            fb = c[0] ^ b[j];
            c  = c >> 1;
            if (fb) c ^= 16'h8408;
        end
        return c;
    endfunction

    task automatic push(input logic [7:0] b, input logic s, input string t);
        exp_q.push_back(b);
        sop_q.push_back(s);
        tag_q.push_back(t);
    endtask

    task automatic put_long(input logic [7:0] di, input int wc, input bit pix);
        logic [15:0] crc = 16'hFFFF;
        logic [7:0]  pb;
        logic [23:0] pv;
        push(di, 1'b1, pix ? "R6" : "R3");
        push(8'(wc), 1'b0, "R3/R9");
        push(8'(wc >> 8), 1'b0, "R3/R9");
        push(calc_ecc({16'(wc), di}), 1'b0, "R4");
        for (int b = 0; b < wc; b++) begin
            if (pix) begin
                pv = pixval(pe + b / 3);
                pb = pv[8 * (b % 3) +: 8];
            end else begin
                pb = 8'h00;
            end
            crc = crc_byte(crc, pb);
            push(pb, 1'b0, pix ? "R7" : "R6");
        end
        if (pix) pe += (wc + 2) / 3;
        push(crc[7:0], 1'b0, "R5");
        push(crc[15:8], 1'b0, "R5");
    endtask

    task automatic build_frame(input int k);
        int total = c_vsa[k] + c_vbp[k] + c_vact[k] + c_vfp[k];
        logic [7:0] di;
        bit act;
        for (int ln = 0; ln < total; ln++) begin
            di = {2'(c_vc[k]), (ln == 0 && c_vsa[k] > 0) ? 6'h01 : 6'h21};
            push(di, 1'b1, "R2");
            push(8'h00, 1'b0, "R2");
            push(8'h00, 1'b0, "R2");
            push(calc_ecc({16'h0000, di}), 1'b0, "R4");
            act = (ln >= c_vsa[k] + c_vbp[k]) && (ln < c_vsa[k] + c_vbp[k] + c_vact[k]);
            put_long({2'(c_vc[k]), 6'h19}, c_hbp[k], 1'b0);
            put_long({2'(c_vc[k]), act ? 6'h3E : 6'h19}, c_hact[k], act);
            put_long({2'(c_vc[k]), 6'h19}, c_hfp[k], 1'b0);
        end
    endtask

    task automatic drive_cfg(input int k);
        cfg_vc      = 2'(c_vc[k]);
        cfg_hact_wc = 16'(c_hact[k]);
        cfg_hbp_wc  = 16'(c_hbp[k]);
        cfg_hfp_wc  = 16'(c_hfp[k]);
        cfg_vsa     = 12'(c_vsa[k]);
        cfg_vbp     = 12'(c_vbp[k]);
        cfg_vact    = 12'(c_vact[k]);
        cfg_vfp     = 12'(c_vfp[k]);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    initial begin
        int  frame = 0;
        int  got   = 0;
        int  cyc   = 0;
        int  pn    = 0;
        bit  took  = 1'b0;
        bit  done  = 1'b0;
        bit  due;
        rst_n     = 1'b0;
        pix_valid = 1'b0;
        pix_data  = pixval(0);
        drive_cfg(0);
        repeat (3) begin
            @(negedge clk);
            check(!out_valid && !out_sop && !pix_ready && !underflow, "R10",
                  "outputs in reset", {out_valid, out_sop, pix_ready, underflow}, 0);
        end
        build_frame(0);
        rst_n = 1'b1;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (took) pn++;
            pix_data  = pixval(pn);
            pix_valid = (c_gap[frame] == 0) || (cyc % c_gap[frame] != 0);
            #1;
            took = pix_valid && pix_ready;
            due  = pix_ready && !pix_valid;
            // R8: stall flag and held output
            check(underflow == due, "R8", "underflow", underflow, due);
            if (due) check(!out_valid, "R8", "out_valid in stall", out_valid, 0);
            if (cyc == 1) check(out_valid, "R10", "first byte after release", out_valid, 1);
            if (out_valid) begin
                check(out_data == exp_q[0], tag_q[0], "byte", out_data, exp_q[0]);
                check(out_sop == sop_q[0], "R1", "sop", out_sop, sop_q[0]);
                void'(exp_q.pop_front());
                void'(sop_q.pop_front());
                void'(tag_q.pop_front());
                got++;
                // R9: change the timing inputs mid-frame
                if (got == 5 && frame + 1 < NCFG) drive_cfg(frame + 1);
                if (exp_q.size() == 0) begin
                    frame++;
                    got = 0;
                    if (frame == NCFG) done = 1'b1;
                    else build_frame(frame);
                end
            end
            if (cyc > WD) begin
                check(1'b0, "R9", "watchdog expired", cyc, WD);
                done = 1'b1;
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule